// File: doc/BRIEF.md
# Instruction Exception Classifier

This block sits beside the decode stage of a CPU pipeline and assigns every accepted instruction either one instruction-exception category or none. An upstream decoder supplies per-instruction class flags together with a valid strobe. Static configuration inputs say whether a floating-point unit and a register bank are fitted, and whether the floating-point unit is held in standby. The execution units supply the divide operands and the floating-point status bits with their enables.

The same restricted instruction is treated differently depending on its position. If it comes right after a delayed branch, it sits in that branch's slot and is reported as a slot-illegal fault. Elsewhere an undefined code is reported as a general illegal fault, and PC-changing, long-form, bank-restore and divide instructions are legal. The block keeps one bit of state for this: whether the next accepted instruction sits in a slot. A pipeline flush clears that bit.

The category is registered, so it appears one clock after the instruction is accepted. It is shown as a one-cycle valid pulse with a 3-bit code.

Top module: `insn_exc_classifier`

## Requirements
- R1: During and right after an active-low reset, excValid is 0, excType is 0 and inSlot is 0.
- R2: An instruction is accepted when insnValid is 1 and flush is 0. One clock after an accepted instruction, excValid is 1 exactly when a category applies, and excType carries its code: 0 none, 1 trap, 2 slot illegal, 3 general illegal, 4 integer division, 5 floating-point. In every other cycle excValid is 0 and excType is 0.
- R3: An accepted delayed branch that raises no exception sets inSlot on the next clock. inSlot holds through cycles with insnValid low. It clears on the clock after the next accepted instruction.
- R4: flush clears inSlot on the next clock. An instruction presented together with flush raises no exception and does not set inSlot.
- R5: While inSlot is 1, an accepted instruction that is effectively undefined, PC-modifying, long-form, a bank restore, or a signed or unsigned divide yields code 2.
- R6: While inSlot is 0, an accepted effectively undefined instruction yields code 3.
- R7: An instruction is effectively undefined when isUndefined is 1. It is also undefined when isFpuOp is 1 and either fpuPresent is 0 or fpuStandby is 1, or when isBankOp is 1 and bankPresent is 0.
- R8: An accepted trap instruction outside a slot yields code 1.
- R9: A signed or unsigned divide with a divisor of zero yields code 4.
- R10: A signed divide of the most negative dividend by all-ones (-1) yields code 4. An unsigned divide with the same operands raises nothing.
- R11: An FPU instruction with a legal FPU yields code 5 when any bit of fpStatus is 1 with the same bit of fpTrapEn also 1. The bit positions are [4] invalid, [3] divide by zero, [2] overflow, [1] underflow, [0] inexact. Status bits whose enable is 0 raise nothing.
- R12: Priority runs from codes 2 and 3 (mutually exclusive), to 1, to 4, to 5. A delayed branch that itself raises an exception does not open a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Pipeline flush; kills the presented instruction and clears slot state |
| insnValid | input | 1 | Decoded instruction present this cycle |
| isTrap | input | 1 | Trap instruction |
| isDelayBranch | input | 1 | Branch with a delay slot |
| isPcModify | input | 1 | Instruction that changes the program counter |
| isLong | input | 1 | 32-bit-long instruction form |
| isBankRestore | input | 1 | Register-bank restore instruction |
| isBankOp | input | 1 | Any register-bank instruction |
| isFpuOp | input | 1 | FPU instruction or FPU-related CPU instruction |
| isDivSigned | input | 1 | Signed integer divide |
| isDivUnsigned | input | 1 | Unsigned integer divide |
| isUndefined | input | 1 | Decoder found no valid opcode |
| fpuPresent | input | 1 | FPU is fitted |
| bankPresent | input | 1 | Register bank is fitted |
| fpuStandby | input | 1 | FPU held in module standby |
| dividend | input | DATA_W | Divide numerator |
| divisor | input | DATA_W | Divide denominator |
| fpStatus | input | 5 | Floating-point status bits of the instruction |
| fpTrapEn | input | 5 | Per-bit floating-point exception enables |
| excValid | output | 1 | One-cycle exception pulse |
| excType | output | 3 | Exception category code |
| inSlot | output | 1 | Next accepted instruction sits in a delay slot |

## Verification
The hardest state to reach is an instruction that sits in a delay slot while some other condition would also fire. Examples are a divide by zero or a trap inside the slot, and a branch left pending across idle cycles or cancelled by a flush. Each scenario first issues a clean delayed branch and confirms that inSlot rose. It then optionally inserts idle cycles or a flush, and only then issues the instruction under test. This exposes both the slot-illegal remapping and the priority over execution-time faults. A branch placed inside a slot checks that a faulting branch opens no new slot.

// File: rtl/insn_exc_pkg.sv
package insn_exc_pkg;

  localparam int EXC_W = 3;
  localparam int FP_FLAG_W = 5;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE    = 3'd0,
    EXC_TRAP    = 3'd1,
    EXC_SLOT    = 3'd2,
    EXC_GENERAL = 3'd3,
    EXC_DIV     = 3'd4,
    EXC_FPU     = 3'd5
  } excCode_t;

  // Strobes from slot control to the classifying datapath
  typedef struct packed {
    logic accept;
    logic inSlot;
  } ctrlStrobes_t;

endpackage

// File: rtl/insn_exc_ctrl.sv
module insn_exc_ctrl
  import insn_exc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         flush,
  input  logic         insnValid,
  input  logic         isDelayBranch,
  input  logic         rawExc,
  output ctrlStrobes_t strobes,
  output logic         slotQ
);

  logic accept;
  logic slotNext;

  assign accept = insnValid && !flush;

  always_comb begin
    slotNext = slotQ;
    if (flush) begin
      slotNext = 1'b0;
    end else if (insnValid) begin
      // a faulting branch never opens a slot
      slotNext = isDelayBranch && !rawExc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slotQ <= 1'b0;
    else       slotQ <= slotNext;
  end

  assign strobes.accept = accept;
  assign strobes.inSlot = slotQ;

endmodule

// File: rtl/insn_exc_dp.sv
module insn_exc_dp
  import insn_exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 isTrap,
  input  logic                 isPcModify,
  input  logic                 isLong,
  input  logic                 isBankRestore,
  input  logic                 isBankOp,
  input  logic                 isFpuOp,
  input  logic                 isDivSigned,
  input  logic                 isDivUnsigned,
  input  logic                 isUndefined,
  input  logic                 fpuPresent,
  input  logic                 bankPresent,
  input  logic                 fpuStandby,
  input  logic [DATA_W-1:0]    dividend,
  input  logic [DATA_W-1:0]    divisor,
  input  logic [FP_FLAG_W-1:0] fpStatus,
  input  logic [FP_FLAG_W-1:0] fpTrapEn,
  output logic                 rawExc,
  output logic                 excValid,
  output logic [EXC_W-1:0]     excType
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MINUS_ONE = {DATA_W{1'b1}};

  logic fpuUsable, undefEff, anyDiv, restricted;
  logic slotIll, genIll, divExc, fpExc;
  excCode_t code;

  assign fpuUsable  = fpuPresent && !fpuStandby;
  assign undefEff   = isUndefined || (isFpuOp && !fpuUsable) || (isBankOp && !bankPresent);
  assign anyDiv     = isDivSigned || isDivUnsigned;
  assign restricted = undefEff || isPcModify || isLong || isBankRestore || anyDiv;

  assign slotIll = strobes.inSlot && restricted;
  assign genIll  = !strobes.inSlot && undefEff;
  assign divExc  = (anyDiv && (divisor == '0))
                || (isDivSigned && (dividend == MOST_NEG) && (divisor == MINUS_ONE));
  assign fpExc   = isFpuOp && |(fpStatus & fpTrapEn);

  always_comb begin
    if (slotIll)     code = EXC_SLOT;
    else if (genIll) code = EXC_GENERAL;
    else if (isTrap) code = EXC_TRAP;
    else if (divExc) code = EXC_DIV;
    else if (fpExc)  code = EXC_FPU;
    else             code = EXC_NONE;
  end

  assign rawExc = (code != EXC_NONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excType  <= EXC_NONE;
    end else if (strobes.accept) begin
      excValid <= rawExc;
      excType  <= code;
    end else begin
      excValid <= 1'b0;
      excType  <= EXC_NONE;
    end
  end

endmodule

// File: rtl/insn_exc_classifier.sv
module insn_exc_classifier
  import insn_exc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              insnValid,
  input  logic              isTrap,
  input  logic              isDelayBranch,
  input  logic              isPcModify,
  input  logic              isLong,
  input  logic              isBankRestore,
  input  logic              isBankOp,
  input  logic              isFpuOp,
  input  logic              isDivSigned,
  input  logic              isDivUnsigned,
  input  logic              isUndefined,
  input  logic              fpuPresent,
  input  logic              bankPresent,
  input  logic              fpuStandby,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  input  logic [4:0]        fpStatus,
  input  logic [4:0]        fpTrapEn,
  output logic              excValid,
  output logic [2:0]        excType,
  output logic              inSlot
);

  ctrlStrobes_t strobes;
  logic rawExc;

  insn_exc_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .flush        (flush),
    .insnValid    (insnValid),
    .isDelayBranch(isDelayBranch),
    .rawExc       (rawExc),
    .strobes      (strobes),
    .slotQ        (inSlot)
  );

  insn_exc_dp #(.DATA_W(DATA_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .isTrap       (isTrap),
    .isPcModify   (isPcModify),
    .isLong       (isLong),
    .isBankRestore(isBankRestore),
    .isBankOp     (isBankOp),
    .isFpuOp      (isFpuOp),
    .isDivSigned  (isDivSigned),
    .isDivUnsigned(isDivUnsigned),
    .isUndefined  (isUndefined),
    .fpuPresent   (fpuPresent),
    .bankPresent  (bankPresent),
    .fpuStandby   (fpuStandby),
    .dividend     (dividend),
    .divisor      (divisor),
    .fpStatus     (fpStatus),
    .fpTrapEn     (fpTrapEn),
    .rawExc       (rawExc),
    .excValid     (excValid),
    .excType      (excType)
  );

endmodule

// File: rtl/insn_exc_checker.sv
module insn_exc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       flush,
  input logic       insnValid,
  input logic       isTrap,
  input logic       isDelayBranch,
  input logic       excValid,
  input logic [2:0] excType,
  input logic       inSlot
);

  AST_PULSE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(insnValid && !flush)); // R2

  AST_TYPE_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |-> (excType == 3'd0)); // R2

  AST_TYPE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excType != 3'd0 && excType <= 3'd5)); // R2

  AST_FLUSH_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |-> !inSlot); // R4

  AST_SLOT_OPENS_ON_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    (inSlot && !$past(inSlot)) |-> $past(insnValid && isDelayBranch && !flush)); // R3

  AST_SLOT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(inSlot && !insnValid && !flush) |-> inSlot); // R3

  AST_SLOT_CODE_IN_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excType == 3'd2) |-> $past(inSlot)); // R5

  AST_GENERAL_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excType == 3'd3) |-> !$past(inSlot)); // R6

  AST_TRAP_FROM_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excType == 3'd1) |-> $past(isTrap)); // R8

endmodule

bind insn_exc_classifier insn_exc_checker uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .flush        (flush),
  .insnValid    (insnValid),
  .isTrap       (isTrap),
  .isDelayBranch(isDelayBranch),
  .excValid     (excValid),
  .excType      (excType),
  .inSlot       (inSlot)
);

// File: tb/insn_exc_classifier_test.sv
module insn_exc_classifier_test;

  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush, insnValid, isTrap, isDelayBranch, isPcModify, isLong;
  logic isBankRestore, isBankOp, isFpuOp, isDivSigned, isDivUnsigned, isUndefined;
  logic fpuPresent, bankPresent, fpuStandby;
  logic [DW-1:0] dividend, divisor;
  logic [4:0] fpStatus, fpTrapEn;
  logic excValid, inSlot;
  logic [2:0] excType;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  insn_exc_classifier #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .flush(flush), .insnValid(insnValid),
    .isTrap(isTrap), .isDelayBranch(isDelayBranch), .isPcModify(isPcModify),
    .isLong(isLong), .isBankRestore(isBankRestore), .isBankOp(isBankOp),
    .isFpuOp(isFpuOp), .isDivSigned(isDivSigned), .isDivUnsigned(isDivUnsigned),
    .isUndefined(isUndefined), .fpuPresent(fpuPresent), .bankPresent(bankPresent),
    .fpuStandby(fpuStandby), .dividend(dividend), .divisor(divisor),
    .fpStatus(fpStatus), .fpTrapEn(fpTrapEn),
    .excValid(excValid), .excType(excType), .inSlot(inSlot)
  );

  task automatic clearInsn();
    insnValid = 0; flush = 0; isTrap = 0; isDelayBranch = 0; isPcModify = 0;
    isLong = 0; isBankRestore = 0; isBankOp = 0; isFpuOp = 0;
    isDivSigned = 0; isDivUnsigned = 0; isUndefined = 0;
    dividend = 32'd100; divisor = 32'd7; fpStatus = 5'd0; fpTrapEn = 5'd0;
  endtask

  // present the set-up instruction for one clock; sample at the following negedge
  task automatic fire();
    insnValid = 1;
    @(negedge clk);
    clearInsn();
  endtask

  task automatic check(string req, logic [2:0] expType, logic expSlot);
    logic expValid;
    expValid = (expType != 3'd0);
    checks++;
    if (excValid !== expValid || excType !== expType || inSlot !== expSlot) begin
      fails++;
      $display("FAIL %s: got valid=%0b type=%0d slot=%0b, expected valid=%0b type=%0d slot=%0b",
               req, excValid, excType, inSlot, expValid, expType, expSlot);
    end
  endtask

  task automatic openSlot(string req);
    isDelayBranch = 1; isPcModify = 1;
    fire();
    check(req, 3'd0, 1'b1);
  endtask

  task automatic testReset();
    check("R1 reset", 3'd0, 1'b0);
  endtask

  task automatic testTrap();
    isTrap = 1; isPcModify = 1; fire();
    check("R8 trap", 3'd1, 1'b0);
    @(negedge clk);
    check("R2 pulse ends", 3'd0, 1'b0);
  endtask

  task automatic testGeneralIllegal();
    isUndefined = 1; fire();
    check("R6 undefined outside slot", 3'd3, 1'b0);
    isFpuOp = 1; fpuPresent = 0; fire();
    check("R7 fpu absent", 3'd3, 1'b0);
    fpuPresent = 1; fpuStandby = 1; isFpuOp = 1; fire();
    check("R7 fpu standby", 3'd3, 1'b0);
    fpuStandby = 0; isFpuOp = 1; fire();
    check("R7 fpu usable", 3'd0, 1'b0);
    bankPresent = 0; isBankOp = 1; fire();
    check("R7 bank absent", 3'd3, 1'b0);
    bankPresent = 1; isBankOp = 1; isBankRestore = 1; fire();
    check("R7 bank present", 3'd0, 1'b0);
    isPcModify = 1; fire();
    check("R6 pc modify legal outside slot", 3'd0, 1'b0);
  endtask

  task automatic testSlotTracking();
    openSlot("R3 branch opens slot");
    @(negedge clk);
    @(negedge clk);
    check("R3 slot held idle", 3'd0, 1'b1);
    fire();
    check("R3 plain insn closes slot", 3'd0, 1'b0);
  endtask

  task automatic testSlotIllegalKinds();
    openSlot("R5 setup"); isUndefined = 1; fire();
    check("R5 undefined in slot", 3'd2, 1'b0);
    openSlot("R5 setup"); isPcModify = 1; fire();
    check("R5 pc modify in slot", 3'd2, 1'b0);
    openSlot("R5 setup"); isLong = 1; fire();
    check("R5 long in slot", 3'd2, 1'b0);
    openSlot("R5 setup"); isBankOp = 1; isBankRestore = 1; fire();
    check("R5 bank restore in slot", 3'd2, 1'b0);
    openSlot("R5 setup"); isDivUnsigned = 1; fire();
    check("R5 divide in slot", 3'd2, 1'b0);
    openSlot("R5 setup"); isFpuOp = 1; fpuPresent = 0; fire();
    fpuPresent = 1;
    check("R5 R7 fpu absent in slot", 3'd2, 1'b0);
  endtask

  task automatic testDivide();
    isDivUnsigned = 1; divisor = 0; fire();
    check("R9 unsigned by zero", 3'd4, 1'b0);
    isDivSigned = 1; divisor = 0; fire();
    check("R9 signed by zero", 3'd4, 1'b0);
    isDivSigned = 1; dividend = 32'h8000_0000; divisor = 32'hFFFF_FFFF; fire();
    check("R10 signed overflow", 3'd4, 1'b0);
    isDivUnsigned = 1; dividend = 32'h8000_0000; divisor = 32'hFFFF_FFFF; fire();
    check("R10 unsigned same operands", 3'd0, 1'b0);
    isDivSigned = 1; dividend = 32'h8000_0001; divisor = 32'hFFFF_FFFF; fire();
    check("R10 not most negative", 3'd0, 1'b0);
  endtask

  task automatic testFpu();
    for (int b = 0; b < 5; b++) begin
      isFpuOp = 1; fpStatus = 5'd1 << b; fpTrapEn = 5'd1 << b; fire();
      check("R11 enabled flag", 3'd5, 1'b0);
    end
    isFpuOp = 1; fpStatus = 5'b10000; fpTrapEn = 5'b01111; fire();
    check("R11 flag disabled", 3'd0, 1'b0);
    fpStatus = 5'b11111; fpTrapEn = 5'b11111; fire();
    check("R11 non-fpu insn", 3'd0, 1'b0);
  endtask

  task automatic testFlush();
    openSlot("R4 setup");
    flush = 1; @(negedge clk); flush = 0;
    check("R4 flush clears slot", 3'd0, 1'b0);
    isUndefined = 1; fire();
    check("R4 after flush general", 3'd3, 1'b0);
    flush = 1; isUndefined = 1; fire();
    check("R4 flushed insn silent", 3'd0, 1'b0);
    flush = 1; isDelayBranch = 1; isPcModify = 1; fire();
    check("R4 flushed branch no slot", 3'd0, 1'b0);
  endtask

  task automatic testPriority();
    openSlot("R12 setup"); isDivSigned = 1; divisor = 0; fire();
    check("R12 slot beats divide", 3'd2, 1'b0);
    openSlot("R12 setup"); isTrap = 1; isPcModify = 1; fire();
    check("R12 slot beats trap", 3'd2, 1'b0);
    isFpuOp = 1; fpuPresent = 0; fpStatus = 5'b11111; fpTrapEn = 5'b11111; fire();
    fpuPresent = 1;
    check("R12 general beats fpu", 3'd3, 1'b0);
    isTrap = 1; isDivUnsigned = 1; divisor = 0; fire();
    check("R12 trap beats divide", 3'd1, 1'b0);
    isDivSigned = 1; isFpuOp = 1; divisor = 0; fpStatus = 5'b1; fpTrapEn = 5'b1; fire();
    check("R12 divide beats fpu", 3'd4, 1'b0);
    openSlot("R12 setup"); isDelayBranch = 1; isPcModify = 1; fire();
    check("R12 faulting branch opens no slot", 3'd2, 1'b0);
  endtask

  initial begin
    clearInsn();
    fpuPresent = 1; bankPresent = 1; fpuStandby = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testTrap();
    testGeneralIllegal();
    testSlotTracking();
    testSlotIllegalKinds();
    testDivide();
    testFpu();
    testFlush();
    testPriority();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got running, expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule